// File: doc/BRIEF.md
# Disk Boot Sector Loader

This block boots a machine by copying a fixed run of disk sectors into main memory without any processor involvement. A small boot-option code picks one of the attached drives. The sequencer then waits for that drive to come online, sends a recalibrate command and waits for the arm to settle. It selects head 1 and waits for the index mark. After that it walks through consecutive sectors. Each drive command is presented as a bus value with a separate tag strobe.

Every sector is handled as three fields in a fixed order: header, label and data. The header and label are only clocked past, so that the controller stays aligned with the track. The data words are written to memory at an address that keeps rising from one sector to the next. Before each field the read circuitry is given a settling delay. After each field the read enable drops and the controller's overrun and ECC flags are checked. A flagged error aborts the boot and leaves a notification word in memory. Both completion and abort deselect the drive and drop the firmware-enable signal.

Top module: `disk_boot_loader`

## Requirements
- R1: While idle, a `start` pulse with `boot_code` equal to `FIRST_CODE+i` (7 selects drive 0, 8 selects drive 1 by default) sets bit i of `drive_sel` and raises `fw_en`. A `start` with any other code leaves `drive_sel` at 0 and `fw_en` low.
- R2: No command is sent before `drv_online` is high. The first command is a recalibrate, with bus value `RECAL_CODE` and the control tag (`cmd_tag` bit 0).
- R3: Each command takes three phases. First the bus value appears with no tag for one cycle. Then the tag is added for exactly one cycle with the bus unchanged. Then the tag is released and the bus value is kept.
- R4: After the recalibrate the sequencer waits for `drv_ready` and then sends the head-select command: bus value 1 with the head tag (`cmd_tag` bit 1).
- R5: An `index_pulse` that arrives before the head-select command has finished is ignored. The first `index_pulse` after it starts the header field of the first sector.
- R6: Within a sector the header field is skipped with `HDR_WORDS` requests, the label with `LBL_WORDS` and the data field with `DATA_WORDS`. Each field's read enable drops only on the count+1-th `rd_req`, and that extra word is discarded. Header and label words are never written to memory.
- R7: Data words are written to consecutive addresses starting at `BUF_BASE`. The address carries on across sectors, without restarting at each sector.
- R8: Before each field, `read_en` stays low for at least `SETTLE_CYCLES` cycles.
- R9: After each field, `read_en` drops and `{err_ecc, err_overrun}` is ANDed with `ERR_MASK` (bit 0 = overrun, bit 1 = ECC). A nonzero result aborts the boot. The abort writes data 1 to memory address `ERR_ADDR` (1) and sets `boot_status` to 1.
- R10: The sector counter is loaded with `SECTORS` when a command is issued and is decremented after each data field. If it is not yet zero, the sequencer waits for `sector_found` before the next header. When it reaches zero, `boot_status` is set to 0.
- R11: On completion or abort, `boot_done` pulses for one cycle. In that same cycle `drive_sel`, `fw_en` and `cmd_bus` are already 0.
- R12: A synchronous `rst` returns the sequencer to idle, with `drive_sel`, `fw_en`, `cmd_bus`, `cmd_tag`, `read_en`, `mem_we`, `boot_status` and `boot_done` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a boot (sampled while idle) |
| boot_code | input | CODE_W | Boot option code that selects the drive |
| drv_online | input | 1 | Drive reports online |
| drv_ready | input | 1 | Drive reports not busy (arm settled) |
| index_pulse | input | 1 | Index mark seen |
| sector_found | input | 1 | Start of next sector seen |
| err_overrun | input | 1 | Controller overrun flag for the last field |
| err_ecc | input | 1 | Controller ECC error flag for the last field |
| rd_req | input | 1 | Data request: one word is available on rd_data |
| rd_data | input | DATA_W | Word from the controller's deserializer |
| drive_sel | output | NUM_DRIVES | One-hot drive select |
| fw_en | output | 1 | Firmware-enable to the controller |
| cmd_bus | output | BUS_W | Drive command bus value |
| cmd_tag | output | 2 | Tag strobes: bit 0 control, bit 1 head |
| read_en | output | 1 | Read enable for the current field |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| boot_status | output | STATUS_W | 0 after success, 1 after abort |
| boot_done | output | 1 | One-cycle pulse when the boot ends |

## Verification
The assertions assume the following about the drive side:
- `rd_req` comes only while `read_en` is high.
- The error flags are valid on the cycle the field is checked.
- The boot option code is stable on the `start` cycle.

The stimulus keeps within these assumptions in three ways:
- A drive model raises requests only after it has sampled `read_en` high, one every other cycle, and stops as soon as `read_en` falls.
- The error flags are raised while the targeted field is still being read.
- Online, ready, index and sector-found are driven only at the protocol points where the sequencer waits for them, except for one deliberately early index pulse.

Every field position in the boot is swept as an abort point, with each of the two error kinds. Clean boots are run on both drives.

// File: rtl/boot_pkg.sv
package boot_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT_ONLINE,
      ST_RECAL,
      ST_WAIT_READY,
      ST_HEAD,
      ST_WAIT_INDEX,
      ST_FIELD,
      ST_CHECK,
      ST_WAIT_SECTOR,
      ST_ABORT,
      ST_FINISH
   } boot_state_e;

   typedef enum logic [1:0] {
      FLD_HDR,
      FLD_LBL,
      FLD_DATA
   } field_e;

endpackage

// File: rtl/boot_cmd_phaser.sv
module boot_cmd_phaser #(
   parameter int BUS_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             go,
   input  logic             clr,
   input  logic [BUS_W-1:0] bus_val,
   input  logic [1:0]       tag_sel,
   output logic [BUS_W-1:0] cmd_bus,
   output logic [1:0]       cmd_tag,
   output logic             done
);

   logic [1:0] phase_q;
   logic [1:0] sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 2'd0;
         sel_q   <= 2'd0;
         cmd_bus <= '0;
         cmd_tag <= 2'd0;
      end else if (clr) begin
         phase_q <= 2'd0;
         cmd_bus <= '0;
         cmd_tag <= 2'd0;
      end else begin
         case (phase_q)
            2'd0: if (go) begin
               cmd_bus <= bus_val;
               sel_q   <= tag_sel;
               phase_q <= 2'd1;
            end
            2'd1: begin
               cmd_tag <= sel_q;
               phase_q <= 2'd2;
            end
            2'd2: begin
               cmd_tag <= 2'd0;
               phase_q <= 2'd3;
            end
            default: phase_q <= 2'd0;
         endcase
      end
   end

   assign done = (phase_q == 2'd3);

   AST_TAG_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (rst)
      $rose(|cmd_tag) |-> (cmd_bus == $past(cmd_bus)) && ($past(cmd_tag) == 2'd0))
      else $error("tag raised without a bus-only phase"); // R3
   AST_BUS_KEPT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
      $fell(|cmd_tag) |-> $stable(cmd_bus))
      else $error("bus changed while tag released"); // R3
   AST_TAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (|cmd_tag) |=> !(|cmd_tag))
      else $error("tag held longer than one cycle"); // R3
   AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cmd_tag))
      else $error("two tags at once"); // R3

endmodule

// File: rtl/boot_field_reader.sv
module boot_field_reader #(
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 16,
   parameter int CNT_W         = 9,
   parameter int SETTLE_CYCLES = 8,
   parameter int BUF_BASE      = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_init,
   input  logic              go,
   input  logic              store,
   input  logic [CNT_W-1:0]  words,
   input  logic              rd_req,
   input  logic [DATA_W-1:0] rd_data,
   output logic              read_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done
);

   localparam int SET_W = $clog2(SETTLE_CYCLES + 1);

   logic              busy_q;
   logic              store_q;
   logic [SET_W-1:0]  settle_q;
   logic [CNT_W-1:0]  remain_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [SET_W-1:0]  gap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         store_q   <= 1'b0;
         settle_q  <= '0;
         remain_q  <= '0;
         ptr_q     <= ADDR_W'(BUF_BASE);
         read_en   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         done      <= 1'b0;
      end else begin
         mem_we <= 1'b0;
         done   <= 1'b0;
         if (addr_init) ptr_q <= ADDR_W'(BUF_BASE);
         if (go) begin
            busy_q   <= 1'b1;
            store_q  <= store;
            settle_q <= SET_W'(SETTLE_CYCLES);
            remain_q <= words;
            read_en  <= 1'b0;
         end else if (busy_q && !read_en) begin
            if (settle_q != '0) settle_q <= settle_q - 1'b1;
            else                read_en  <= 1'b1;
         end else if (read_en && rd_req) begin
            if (remain_q == '0) begin
               read_en <= 1'b0;
               busy_q  <= 1'b0;
               done    <= 1'b1;
            end else begin
               remain_q <= remain_q - 1'b1;
               if (store_q) begin
                  mem_we    <= 1'b1;
                  mem_addr  <= ptr_q;
                  mem_wdata <= rd_data;
                  ptr_q     <= ptr_q + 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                             gap_q <= '0;
      else if (read_en)                    gap_q <= '0;
      else if (gap_q != SET_W'(SETTLE_CYCLES)) gap_q <= gap_q + 1'b1;
   end

   AST_SETTLE_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
      $rose(read_en) |-> (gap_q == SET_W'(SETTLE_CYCLES)))
      else $error("read enabled before settling"); // R8
   AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> ($past(rd_req) && $past(read_en)))
      else $error("memory write without a data request"); // R6
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1))
      else $error("write address not consecutive"); // R7

endmodule

// File: rtl/disk_boot_loader.sv
module disk_boot_loader #(
   parameter int              DATA_W        = 16,
   parameter int              ADDR_W        = 16,
   parameter int              BUS_W         = 10,
   parameter int              STATUS_W      = 8,
   parameter int              CODE_W        = 4,
   parameter int              NUM_DRIVES    = 2,
   parameter int              FIRST_CODE    = 7,
   parameter int              SECTORS       = 28,
   parameter int              HDR_WORDS     = 2,
   parameter int              LBL_WORDS     = 10,
   parameter int              DATA_WORDS    = 256,
   parameter int              BUF_BASE      = 256,
   parameter int              SETTLE_CYCLES = 8,
   parameter int              ERR_ADDR      = 1,
   parameter int              ERR_CODE      = 1,
   parameter logic [BUS_W-1:0] RECAL_CODE   = 'h044,
   parameter logic [1:0]      ERR_MASK      = 2'b11
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [CODE_W-1:0]     boot_code,
   input  logic                  drv_online,
   input  logic                  drv_ready,
   input  logic                  index_pulse,
   input  logic                  sector_found,
   input  logic                  err_overrun,
   input  logic                  err_ecc,
   input  logic                  rd_req,
   input  logic [DATA_W-1:0]     rd_data,
   output logic [NUM_DRIVES-1:0] drive_sel,
   output logic                  fw_en,
   output logic [BUS_W-1:0]      cmd_bus,
   output logic [1:0]            cmd_tag,
   output logic                  read_en,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [STATUS_W-1:0]   boot_status,
   output logic                  boot_done
);
   import boot_pkg::*;

   localparam int MAX_HL    = (HDR_WORDS > LBL_WORDS) ? HDR_WORDS : LBL_WORDS;
   localparam int MAX_WORDS = (MAX_HL > DATA_WORDS) ? MAX_HL : DATA_WORDS;
   localparam int CNT_W     = $clog2(MAX_WORDS + 1);
   localparam int SEC_W     = $clog2(SECTORS + 1);

   if (DATA_WORDS < 1 || (DATA_WORDS & (DATA_WORDS - 1)) != 0) begin : g_chk_words
      $error("DATA_WORDS must be a power of two");
   end
   if (BUF_BASE % DATA_WORDS != 0 || BUF_BASE <= ERR_ADDR) begin : g_chk_base
      $error("BUF_BASE must be page aligned and above ERR_ADDR");
   end
   if (NUM_DRIVES < 1 || FIRST_CODE + NUM_DRIVES > (1 << CODE_W)) begin : g_chk_drv
      $error("drive codes do not fit CODE_W");
   end
   if (SECTORS < 1 || SETTLE_CYCLES < 1 || ERR_CODE == 0) begin : g_chk_misc
      $error("SECTORS, SETTLE_CYCLES and ERR_CODE must be nonzero");
   end

   boot_state_e           state_q;
   field_e                field_q;
   logic [NUM_DRIVES-1:0] code_hit;
   logic [SEC_W-1:0]      sec_cnt_q;
   logic                  cmd_go_q;
   logic [BUS_W-1:0]      cmd_val_q;
   logic [1:0]            cmd_sel_q;
   logic                  cmd_done;
   logic                  cmd_clr;
   logic                  fr_go_q;
   logic                  addr_init_q;
   logic [CNT_W-1:0]      fr_words;
   logic                  fr_store;
   logic                  fr_done;
   logic                  fr_we;
   logic [ADDR_W-1:0]     fr_addr;
   logic [DATA_W-1:0]     fr_wdata;
   logic [1:0]            err_vec;

   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
      assign code_hit[i] = (boot_code == CODE_W'(FIRST_CODE + i));
   end

   assign err_vec = {err_ecc, err_overrun};
   assign cmd_clr = (state_q == ST_ABORT) || (state_q == ST_FINISH);

   always_comb begin
      case (field_q)
         FLD_HDR: fr_words = CNT_W'(HDR_WORDS);
         FLD_LBL: fr_words = CNT_W'(LBL_WORDS);
         default: fr_words = CNT_W'(DATA_WORDS);
      endcase
   end
   assign fr_store = (field_q == FLD_DATA);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         field_q     <= FLD_HDR;
         drive_sel   <= '0;
         fw_en       <= 1'b0;
         boot_status <= '0;
         boot_done   <= 1'b0;
         sec_cnt_q   <= '0;
         cmd_go_q    <= 1'b0;
         cmd_val_q   <= '0;
         cmd_sel_q   <= 2'd0;
         fr_go_q     <= 1'b0;
         addr_init_q <= 1'b0;
      end else begin
         cmd_go_q    <= 1'b0;
         fr_go_q     <= 1'b0;
         addr_init_q <= 1'b0;
         boot_done   <= 1'b0;
         case (state_q)
            ST_IDLE: if (start && (|code_hit)) begin
               drive_sel   <= code_hit;
               fw_en       <= 1'b1;
               addr_init_q <= 1'b1;
               state_q     <= ST_WAIT_ONLINE;
            end
            ST_WAIT_ONLINE: if (drv_online) begin
               cmd_val_q <= RECAL_CODE;
               cmd_sel_q <= 2'b01;
               cmd_go_q  <= 1'b1;
               sec_cnt_q <= SEC_W'(SECTORS);
               state_q   <= ST_RECAL;
            end
            ST_RECAL: if (cmd_done) state_q <= ST_WAIT_READY;
            ST_WAIT_READY: if (drv_ready) begin
               cmd_val_q <= BUS_W'(1);
               cmd_sel_q <= 2'b10;
               cmd_go_q  <= 1'b1;
               sec_cnt_q <= SEC_W'(SECTORS);
               state_q   <= ST_HEAD;
            end
            ST_HEAD: if (cmd_done) state_q <= ST_WAIT_INDEX;
            ST_WAIT_INDEX: if (index_pulse) begin
               field_q <= FLD_HDR;
               fr_go_q <= 1'b1;
               state_q <= ST_FIELD;
            end
            ST_FIELD: if (fr_done) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (|(err_vec & ERR_MASK)) begin
                  state_q <= ST_ABORT;
               end else begin
                  case (field_q)
                     FLD_HDR: begin
                        field_q <= FLD_LBL;
                        fr_go_q <= 1'b1;
                        state_q <= ST_FIELD;
                     end
                     FLD_LBL: begin
                        field_q <= FLD_DATA;
                        fr_go_q <= 1'b1;
                        state_q <= ST_FIELD;
                     end
                     default: begin
                        sec_cnt_q <= sec_cnt_q - 1'b1;
                        if (sec_cnt_q == SEC_W'(1)) state_q <= ST_FINISH;
                        else                        state_q <= ST_WAIT_SECTOR;
                     end
                  endcase
               end
            end
            ST_WAIT_SECTOR: if (sector_found) begin
               field_q <= FLD_HDR;
               fr_go_q <= 1'b1;
               state_q <= ST_FIELD;
            end
            ST_ABORT, ST_FINISH: begin
               boot_status <= (state_q == ST_ABORT) ? STATUS_W'(ERR_CODE) : '0;
               drive_sel   <= '0;
               fw_en       <= 1'b0;
               boot_done   <= 1'b1;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   boot_cmd_phaser #(
      .BUS_W (BUS_W)
   ) u_cmd (
      .clk     (clk),
      .rst     (rst),
      .go      (cmd_go_q),
      .clr     (cmd_clr),
      .bus_val (cmd_val_q),
      .tag_sel (cmd_sel_q),
      .cmd_bus (cmd_bus),
      .cmd_tag (cmd_tag),
      .done    (cmd_done)
   );

   boot_field_reader #(
      .DATA_W        (DATA_W),
      .ADDR_W        (ADDR_W),
      .CNT_W         (CNT_W),
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .BUF_BASE      (BUF_BASE)
   ) u_field (
      .clk       (clk),
      .rst       (rst),
      .addr_init (addr_init_q),
      .go        (fr_go_q),
      .store     (fr_store),
      .words     (fr_words),
      .rd_req    (rd_req),
      .rd_data   (rd_data),
      .read_en   (read_en),
      .mem_we    (fr_we),
      .mem_addr  (fr_addr),
      .mem_wdata (fr_wdata),
      .done      (fr_done)
   );

   assign mem_we    = fr_we || (state_q == ST_ABORT);
   assign mem_addr  = (state_q == ST_ABORT) ? ADDR_W'(ERR_ADDR) : fr_addr;
   assign mem_wdata = (state_q == ST_ABORT) ? DATA_W'(ERR_CODE) : fr_wdata;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(drive_sel))
      else $error("more than one drive selected"); // R1
   AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (rst)
      boot_done |-> (drive_sel == '0) && !fw_en && (cmd_bus == '0))
      else $error("drive still selected at end"); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      boot_done |=> !boot_done)
      else $error("done longer than one cycle"); // R11
   AST_NO_READ_DURING_TAG: assert property (@(posedge clk) disable iff (rst)
      (|cmd_tag) |-> !read_en)
      else $error("read enabled during a command"); // R4
   AST_READ_NEEDS_FW: assert property (@(posedge clk) disable iff (rst)
      read_en |-> fw_en)
      else $error("read enabled while firmware disabled"); // R9
   AST_ERR_NOTIFY: assert property (@(posedge clk) disable iff (rst)
      (mem_we && mem_addr == ADDR_W'(ERR_ADDR)) |=> boot_done && (boot_status == STATUS_W'(ERR_CODE)))
      else $error("error notification not followed by abort status"); // R9

endmodule

// File: tb/disk_boot_loader_test.sv
module disk_boot_loader_test;

   localparam int DW      = 8;
   localparam int SECS    = 3;
   localparam int HW      = 2;
   localparam int LW      = 3;
   localparam int BASE    = 32;
   localparam int SETTLE  = 3;
   localparam logic [9:0] RECAL = 10'h044;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [3:0]  boot_code = 4'd0;
   logic        drv_online = 1'b0;
   logic        drv_ready = 1'b0;
   logic        index_pulse = 1'b0;
   logic        sector_found = 1'b0;
   logic        err_overrun = 1'b0;
   logic        err_ecc = 1'b0;
   logic        rd_req = 1'b0;
   logic [15:0] rd_data = 16'd0;
   logic [1:0]  drive_sel;
   logic        fw_en;
   logic [9:0]  cmd_bus;
   logic [1:0]  cmd_tag;
   logic        read_en;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [7:0]  boot_status;
   logic        boot_done;

   int n_checks = 0;
   int n_fail   = 0;
   int wr_idx, err_writes, tag_pulses, fld_cnt, low_cnt;
   bit done_seen;
   logic [9:0] prev_bus;
   logic [1:0] prev_tag;
   logic       prev_ren;

   always #5 clk = ~clk;

   disk_boot_loader #(
      .SECTORS(SECS), .HDR_WORDS(HW), .LBL_WORDS(LW), .DATA_WORDS(DW),
      .BUF_BASE(BASE), .SETTLE_CYCLES(SETTLE), .RECAL_CODE(RECAL)
   ) uut (
      .clk(clk), .rst(rst), .start(start), .boot_code(boot_code),
      .drv_online(drv_online), .drv_ready(drv_ready), .index_pulse(index_pulse),
      .sector_found(sector_found), .err_overrun(err_overrun), .err_ecc(err_ecc),
      .rd_req(rd_req), .rd_data(rd_data), .drive_sel(drive_sel), .fw_en(fw_en),
      .cmd_bus(cmd_bus), .cmd_tag(cmd_tag), .read_en(read_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .boot_status(boot_status),
      .boot_done(boot_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: commands, memory writes, settle gap, end of boot
   always @(negedge clk) begin
      if (!rst) begin
         if (cmd_tag != 2'd0 && prev_tag == 2'd0) begin
            tag_pulses++;
            chk(prev_bus == cmd_bus, "R3", "bus-only phase before tag", int'(prev_bus), int'(cmd_bus));
            if (cmd_tag == 2'b01)
               chk(cmd_bus == RECAL, "R2", "recalibrate bus value", int'(cmd_bus), int'(RECAL));
            else
               chk(cmd_tag == 2'b10 && cmd_bus == 10'd1, "R4", "head select tag/bus",
                   int'({cmd_tag, cmd_bus}), int'({2'b10, 10'd1}));
         end
         if (cmd_tag == 2'd0 && prev_tag != 2'd0)
            chk(cmd_bus == prev_bus, "R3", "bus kept on tag release", int'(cmd_bus), int'(prev_bus));
         if (cmd_tag != 2'd0 && prev_tag != 2'd0)
            chk(1'b0, "R3", "tag wider than one cycle", int'(cmd_tag), 0);
         if (mem_we) begin
            if (mem_addr == 16'd1) begin
               err_writes++;
               chk(mem_wdata == 16'd1, "R9", "error notify data", int'(mem_wdata), 1);
            end else begin
               chk(mem_addr == 16'(BASE + wr_idx), "R7", "write address", int'(mem_addr), BASE + wr_idx);
               chk(mem_wdata == 16'hD000 + 16'(wr_idx), "R6", "write data", int'(mem_wdata),
                   int'(16'hD000 + 16'(wr_idx)));
               wr_idx++;
            end
         end
         if (read_en && !prev_ren)
            chk(low_cnt >= SETTLE, "R8", "settle gap", low_cnt, SETTLE);
         low_cnt = read_en ? 0 : low_cnt + 1;
         if (boot_done) begin
            done_seen = 1'b1;
            chk(drive_sel == 2'b00 && !fw_en && cmd_bus == 10'd0, "R11", "deselect at done",
                int'({drive_sel, fw_en, cmd_bus}), 0);
         end
      end
      prev_bus = cmd_bus;
      prev_tag = cmd_tag;
      prev_ren = read_en;
   end

   task automatic pulse_start(input int code);
      @(negedge clk); start = 1'b1; boot_code = 4'(code);
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run_boot(input int code, input int err_fld, input int err_kind);
      int g, kind, sec, nreq, words, exp_wr;
      wr_idx = 0; err_writes = 0; done_seen = 1'b0; fld_cnt = 0; tag_pulses = 0;
      pulse_start(code);
      repeat (2) @(negedge clk);
      chk(fw_en == 1'b1, "R1", "fw_en after start", int'(fw_en), 1);
      chk(drive_sel == ((code == 7) ? 2'b01 : 2'b10), "R1", "drive select",
          int'(drive_sel), (code == 7) ? 1 : 2);
      repeat (5) @(negedge clk);
      chk(tag_pulses == 0 && cmd_bus == 10'd0, "R2", "no command before online", tag_pulses, 0);
      drv_online = 1'b1;
      while (tag_pulses < 1) @(negedge clk);
      @(negedge clk); index_pulse = 1'b1;
      @(negedge clk); index_pulse = 1'b0;
      repeat (6) @(negedge clk);
      chk(tag_pulses == 1, "R4", "no head select before ready", tag_pulses, 1);
      drv_ready = 1'b1;
      while (tag_pulses < 2) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(read_en == 1'b0, "R5", "early index ignored", int'(read_en), 0);
      index_pulse = 1'b1;
      @(negedge clk); index_pulse = 1'b0;
      while (!done_seen) begin
         if (read_en) begin
            g = fld_cnt; fld_cnt++;
            kind = g % 3; sec = g / 3;
            if (g == err_fld) begin
               if (err_kind == 0) err_overrun = 1'b1;
               else               err_ecc = 1'b1;
            end
            nreq = 0;
            while (read_en) begin
               rd_req = 1'b1;
               rd_data = (kind == 2) ? 16'hD000 + 16'(sec * DW + nreq) : 16'hEEEE;
               @(negedge clk); rd_req = 1'b0; nreq++;
               @(negedge clk);
            end
            words = (kind == 0) ? HW : (kind == 1) ? LW : DW;
            chk(nreq == words + 1, "R6", "requests per field (count+1)", nreq, words + 1);
            if (kind == 2 && sec < SECS - 1 && (err_fld < 0 || err_fld > g)) begin
               repeat (5) @(negedge clk);
               chk(read_en == 1'b0 && fld_cnt == g + 1, "R10", "waits for sector found",
                   int'(read_en), 0);
               sector_found = 1'b1;
               @(negedge clk); sector_found = 1'b0;
            end
         end else begin
            @(negedge clk);
         end
      end
      if (err_fld < 0) begin
         exp_wr = SECS * DW;
         chk(boot_status == 8'd0, "R10", "success status", int'(boot_status), 0);
         chk(fld_cnt == 3 * SECS, "R10", "field count", fld_cnt, 3 * SECS);
      end else begin
         exp_wr = (err_fld / 3) * DW + ((err_fld % 3 == 2) ? DW : 0);
         chk(boot_status == 8'd1, "R9", "abort status", int'(boot_status), 1);
         chk(fld_cnt == err_fld + 1, "R9", "abort after flagged field", fld_cnt, err_fld + 1);
      end
      chk(wr_idx == exp_wr, "R7", "stored words", wr_idx, exp_wr);
      chk(err_writes == ((err_fld < 0) ? 0 : 1), "R9", "error notify writes", err_writes,
          (err_fld < 0) ? 0 : 1);
      err_overrun = 1'b0; err_ecc = 1'b0; drv_online = 1'b0; drv_ready = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk({drive_sel, fw_en, cmd_tag, read_en, mem_we, boot_done} == 8'd0 && cmd_bus == 10'd0
          && boot_status == 8'd0, "R12", "reset state",
          int'({drive_sel, fw_en, cmd_tag, read_en, mem_we, boot_done}), 0);
      for (int c = 0; c < 16; c++) begin
         if (c != 7 && c != 8) begin
            pulse_start(c);
            @(negedge clk);
            chk(fw_en == 1'b0 && drive_sel == 2'b00, "R1", "invalid code ignored",
                int'({drive_sel, fw_en}), 0);
         end
      end
      run_boot(7, -1, 0);
      run_boot(8, -1, 0);
      for (int f = 0; f < 3 * SECS; f++) begin
         for (int k = 0; k < 2; k++) begin
            run_boot((f % 2 == 0) ? 8 : 7, f, k);
         end
      end
      // R12: synchronous reset in the middle of a boot
      tag_pulses = 0;
      pulse_start(7);
      drv_online = 1'b1;
      while (tag_pulses < 1) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk({drive_sel, fw_en, cmd_tag, read_en, mem_we, boot_done} == 8'd0 && cmd_bus == 10'd0,
          "R12", "reset mid-boot", int'({drive_sel, fw_en, cmd_tag, cmd_bus}), 0);
      drv_online = 1'b0;
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(tag_pulses == 1 && fw_en == 1'b0, "R12", "idle after reset", tag_pulses, 1);
      summary();
      $finish;
   end

endmodule